// File: doc/BRIEF.md
# Misaligned Load/Store Aligner

This block sits between a core's load/store path and a memory bus that moves only whole, aligned 32-bit words. The core issues byte-addressed requests of one, two or four bytes at any address. When an access fits inside one bus word, the block issues a single bus transaction. When it crosses a word boundary, the block issues two transactions back to back: first the lower word, then the next word up. For loads, the bytes from the returned words are shifted into place and ORed into one value. For stores, the value is scattered onto the correct byte lanes and each write carries byte enables.

A configuration input chooses the byte order. In little-endian order, the value's least significant byte lives at the lowest address. In big-endian order, its most significant byte lives there. On the bus, lane k (bits 8k+7:8k) always carries the byte at word address + k.

The control path is a four-state machine:
- `ST_IDLE` accepts a request.
- `ST_BUS0` drives the lower-word transaction.
- `ST_BUS1` drives the upper-word transaction and captures the lower read word.
- `ST_FINISH` presents the response.

Transitions:
- idle to BUS0 on an accepted request.
- BUS0 to BUS1 when the access is split, otherwise BUS0 to FINISH.
- BUS1 to FINISH.
- FINISH back to idle.

The bus returns read data in the cycle after a read transaction.

Top module: `lsu_align`

## Requirements
- R1: After reset, `req_ready` is 1 and both `bus_req` and `rsp_valid` are 0.
- R2: Every bus transaction carries an address whose two low bits are zero.
- R3: An access whose bytes all lie in one word issues exactly one bus transaction, in the cycle after acceptance.
- R4: An access that crosses a word boundary issues two transactions in consecutive cycles. The first goes to the address with its low two bits cleared; the second goes to that address plus 4, wrapping within the address width.
- R5: `req_ready` is high only when idle. It stays low from acceptance until the response. `rsp_valid` pulses for one cycle, in the cycle after the last bus transaction, and `req_ready` returns the cycle after that.
- R6: In little-endian mode, a load returns the byte at the lowest address as the least significant byte.
- R7: In big-endian mode, a load returns the byte at the lowest address as the most significant byte.
- R8: One- and two-byte loads are sign-extended when `req_signed` is 1 and zero-extended when it is 0.
- R9: Each bus transaction's `bus_be` sets exactly the lanes of the access bytes that lie in that word.
- R10: A store writes the value's bytes to the addressed bytes in the selected byte order, and leaves every other byte unchanged.
- R11: `req_size` codes 0, 1 and 2 mean 1, 2 and 4 bytes; code 3 is treated as 4 bytes.
- R12: The byte order is sampled at acceptance. Changing `cfg_big_endian` while an access is in flight does not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_big_endian | input | 1 | 1 selects big-endian byte order |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code: 0 = byte, 1 = half, 2 or 3 = word |
| req_signed | input | 1 | Sign-extend sub-word loads |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Store value, right-aligned |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Load result (zero for stores) |
| bus_req | output | 1 | Bus transaction this cycle |
| bus_we | output | 1 | Bus transaction is a write |
| bus_addr | output | AW | Word-aligned bus address |
| bus_be | output | DW/8 | Byte-lane enables |
| bus_wdata | output | DW | Write data on lanes |
| bus_rdata | input | DW | Read data, valid the cycle after a read |

## Verification
The assertions check the following on every cycle:
- word alignment of bus addresses;
- the back-to-back ordering and the plus-4 step of the two halves of a split;
- the cap of two transactions;
- the lanes a split must touch on each side of the boundary;
- the busy/response handshake.

Only the bench's scenarios can show that merged load values, extension, byte order, written memory contents and the per-word enable masks are correct, because these depend on data and on the address offset across a whole access. The same holds for the sampling of byte order at acceptance.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUS0   = 2'd1,
        ST_BUS1   = 2'd2,
        ST_FINISH = 2'd3
    } state_t;
endpackage

// File: rtl/lsu_align_pack.sv
// Scatters a right-aligned store value onto a two-word lane window.
module lsu_align_pack #(
    parameter int DW    = 32,
    parameter int BYTES = DW / 8,
    parameter int OFFW  = $clog2(BYTES),
    parameter int SZW   = $clog2(OFFW + 1)
) (
    input  logic [OFFW-1:0]    offset,
    input  logic [SZW-1:0]     size,
    input  logic               big,
    input  logic [DW-1:0]      value,
    output logic [2*DW-1:0]    lanes,
    output logic [2*BYTES-1:0] enables
);
    int                 nb;
    logic [2*DW-1:0]    placed;
    logic [2*BYTES-1:0] mask;

    assign nb = (int'(size) > OFFW) ? BYTES : (32'd1 << size);

    always_comb begin
        placed = '0;
        mask   = '0;
        for (int k = 0; k < BYTES; k++) begin
            if (k < nb) begin
                placed[8*k +: 8] = big ? value[8*(nb-1-k) +: 8] : value[8*k +: 8];
                mask[k]          = 1'b1;
            end
        end
    end

    assign lanes   = placed << {offset, 3'b000};
    assign enables = mask << offset;
endmodule

// File: rtl/lsu_align_unpack.sv
// Gathers the access bytes from a two-word window, orders and extends them.
module lsu_align_unpack #(
    parameter int DW    = 32,
    parameter int BYTES = DW / 8,
    parameter int OFFW  = $clog2(BYTES),
    parameter int SZW   = $clog2(OFFW + 1)
) (
    input  logic [2*DW-1:0] window,
    input  logic [OFFW-1:0] offset,
    input  logic [SZW-1:0]  size,
    input  logic            big,
    input  logic            sext,
    output logic [DW-1:0]   value
);
    int              nb;
    logic [2*DW-1:0] shifted;
    logic [DW-1:0]   raw;
    logic            fill;

    assign nb      = (int'(size) > OFFW) ? BYTES : (32'd1 << size);
    assign shifted = window >> {offset, 3'b000};

    always_comb begin
        raw = '0;
        for (int k = 0; k < BYTES; k++) begin
            if (k < nb) begin
                raw[8*(big ? (nb-1-k) : k) +: 8] = shifted[8*k +: 8];
            end
        end
    end

    assign fill = sext & raw[8*nb-1];

    always_comb begin
        value = raw;
        for (int k = 0; k < BYTES; k++) begin
            if (k >= nb) begin
                value[8*k +: 8] = {8{fill}};
            end
        end
    end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
    import lsu_align_pkg::*;
#(
    parameter int  AW    = 16,
    parameter int  DW    = 32,
    localparam int BYTES = DW / 8,
    localparam int OFFW  = $clog2(BYTES),
    localparam int SZW   = $clog2(OFFW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_big_endian,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [SZW-1:0]   req_size,
    input  logic             req_signed,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic             bus_req,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic [BYTES-1:0] bus_be,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata
);
    state_t state, state_nx;

    logic [AW-1:0]      r_addr;
    logic [SZW-1:0]     r_size;
    logic               r_sext;
    logic               r_we;
    logic               r_big;
    logic [DW-1:0]      r_wdata;
    logic [DW-1:0]      r_lowword;

    logic [2*DW-1:0]    st_lanes;
    logic [2*BYTES-1:0] lane_en;
    logic               split;
    logic [AW-1:0]      addr_lo;
    logic [AW-1:0]      addr_hi;
    logic [2*DW-1:0]    ld_window;
    logic [DW-1:0]      ld_value;
    logic               accept;

    assign accept  = req_valid && (state == ST_IDLE);
    assign split   = |lane_en[2*BYTES-1:BYTES];
    assign addr_lo = {r_addr[AW-1:OFFW], {OFFW{1'b0}}};
    assign addr_hi = addr_lo + AW'(BYTES);

    lsu_align_pack #(.DW(DW)) u_pack (
        .offset  (r_addr[OFFW-1:0]),
        .size    (r_size),
        .big     (r_big),
        .value   (r_wdata),
        .lanes   (st_lanes),
        .enables (lane_en)
    );

    assign ld_window = split ? {bus_rdata, r_lowword} : {{DW{1'b0}}, bus_rdata};

    lsu_align_unpack #(.DW(DW)) u_unpack (
        .window (ld_window),
        .offset (r_addr[OFFW-1:0]),
        .size   (r_size),
        .big    (r_big),
        .sext   (r_sext),
        .value  (ld_value)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = req_valid ? ST_BUS0 : ST_IDLE;
            ST_BUS0:   state_nx = split ? ST_BUS1 : ST_FINISH;
            ST_BUS1:   state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
        endcase
    end

    // Request capture and lower read word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr    <= '0;
            r_size    <= '0;
            r_sext    <= 1'b0;
            r_we      <= 1'b0;
            r_big     <= 1'b0;
            r_wdata   <= '0;
            r_lowword <= '0;
        end else begin
            if (accept) begin
                r_addr  <= req_addr;
                r_size  <= req_size;
                r_sext  <= req_signed;
                r_we    <= req_write;
                r_big   <= cfg_big_endian;
                r_wdata <= req_wdata;
            end
            if (state == ST_BUS1) begin
                r_lowword <= bus_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = addr_lo;
        bus_be    = '0;
        bus_wdata = '0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_BUS0: begin
                bus_req   = 1'b1;
                bus_we    = r_we;
                bus_addr  = addr_lo;
                bus_be    = lane_en[BYTES-1:0];
                bus_wdata = st_lanes[DW-1:0];
            end
            ST_BUS1: begin
                bus_req   = 1'b1;
                bus_we    = r_we;
                bus_addr  = addr_hi;
                bus_be    = lane_en[2*BYTES-1:BYTES];
                bus_wdata = st_lanes[2*DW-1:DW];
            end
            ST_FINISH: begin
                rsp_valid = 1'b1;
                rsp_rdata = r_we ? '0 : ld_value;
            end
        endcase
    end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
    parameter int  AW    = 16,
    parameter int  DW    = 32,
    localparam int BYTES = DW / 8,
    localparam int OFFW  = $clog2(BYTES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             bus_req,
    input logic [AW-1:0]    bus_addr,
    input logic [BYTES-1:0] bus_be
);
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[OFFW-1:0] == '0));

    a_r4_next_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> (bus_addr == $past(bus_addr) + AW'(BYTES)));

    a_r4_at_most_two: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |=> !bus_req);

    a_r3_bus_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bus_req);

    a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r5_rsp_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> rsp_valid);

    a_r5_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    a_r9_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_be != '0));

    a_r9_split_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> (bus_be[0] && $past(bus_be[BYTES-1])));
endmodule

bind lsu_align lsu_align_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be)
);

// File: tb/lsu_align_bench.sv
`timescale 1ns/1ps
module lsu_align_bench;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_big_endian;
    logic          req_valid;
    logic          req_ready;
    logic          req_write;
    logic [1:0]    req_size;
    logic          req_signed;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          bus_req;
    logic          bus_we;
    logic [AW-1:0] bus_addr;
    logic [3:0]    bus_be;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;

    always #4 clk = ~clk;

    lsu_align #(.AW(AW), .DW(DW)) u_lsu_align (
        .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    logic [31:0] mem [64];
    logic [7:0]  ref_mem [256];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Single-cycle word memory; lane k holds byte at word address + k
    always @(posedge clk) begin
        if (bus_req) begin
            bus_rdata <= mem[bus_addr[7:2]];
            if (bus_we) begin
                for (int l = 0; l < 4; l++) begin
                    if (bus_be[l]) mem[bus_addr[7:2]][8*l +: 8] <= bus_wdata[8*l +: 8];
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input int sz);
        return (sz >= 2) ? 4 : (1 << sz);
    endfunction

    function automatic logic [31:0] exp_load(input int addr, input int sz, input bit big, input bit sx);
        int n = nbytes(sz);
        logic [31:0] v = '0;
        for (int k = 0; k < n; k++) begin
            v[8*(big ? (n-1-k) : k) +: 8] = ref_mem[(addr + k) & 255];
        end
        if (sx && n < 4 && v[8*n-1]) begin
            for (int b = 8*n; b < 32; b++) v[b] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [31:0] ref_word(input int widx);
        return {ref_mem[4*widx+3], ref_mem[4*widx+2], ref_mem[4*widx+1], ref_mem[4*widx]};
    endfunction

    task automatic do_op(input bit we, input int sz, input bit sx, input int addr,
                         input logic [31:0] wdata, input bit big, input bit flip);
        int n = nbytes(sz);
        int o = addr % 4;
        bit spl = (o + n) > 4;
        int nbus = 0;
        logic [15:0] a_seen [2];
        logic [3:0]  be_seen [2];
        bit got = 0;
        bit busy_ok = 1;
        logic [31:0] rd = '0;
        logic [7:0] mask;
        logic [15:0] a0;
        string tag;
        @(negedge clk);
        check(req_ready == 1'b1, "R5 ready idle", 64'(req_ready), 64'd1);
        cfg_big_endian = big;
        req_valid = 1; req_write = we; req_size = 2'(sz); req_signed = sx;
        req_addr = 16'(addr); req_wdata = wdata;
        @(posedge clk);
        #1;
        req_valid = 0;
        if (flip) cfg_big_endian = !big;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (req_ready) busy_ok = 0;
            if (bus_req) begin
                if (nbus < 2) begin
                    a_seen[nbus] = bus_addr;
                    be_seen[nbus] = bus_be;
                end
                nbus++;
            end
            if (rsp_valid) begin
                got = 1;
                rd = rsp_rdata;
                break;
            end
        end
        check(got && busy_ok, "R5 busy then response", {62'd0, got, busy_ok}, 64'd3);
        check(nbus == (spl ? 2 : 1), spl ? "R4 two bus cycles" : "R3 one bus cycle", 64'(nbus), spl ? 64'd2 : 64'd1);
        mask = 8'(((1 << n) - 1) << o);
        a0 = 16'(addr) & 16'hFFFC;
        if (nbus >= 1) begin
            check(a_seen[0] == a0, "R2 first word address", 64'(a_seen[0]), 64'(a0));
            check(be_seen[0] == mask[3:0], "R9 first enables", 64'(be_seen[0]), 64'(mask[3:0]));
        end
        if (spl && nbus == 2) begin
            check(a_seen[1] == a0 + 16'd4, "R4 second word address", 64'(a_seen[1]), 64'(a0 + 16'd4));
            check(be_seen[1] == mask[7:4], "R9 second enables", 64'(be_seen[1]), 64'(mask[7:4]));
        end
        if (we) begin
            for (int k = 0; k < n; k++) begin
                ref_mem[(addr + k) & 255] = wdata[8*(big ? (n-1-k) : k) +: 8];
            end
            for (int w = 0; w < (spl ? 2 : 1); w++) begin
                int wi = ((a0 >> 2) + w) & 63;
                check(mem[wi] == ref_word(wi), flip ? "R12 R10 store bytes" : "R10 store bytes",
                      64'(mem[wi]), 64'(ref_word(wi)));
            end
        end else begin
            logic [31:0] e = exp_load(addr, sz, big, sx);
            tag = big ? "R7 load" : "R6 load";
            if (n < 4) tag = {tag, " R8 ext"};
            if (sz == 3) tag = {tag, " R11 size3"};
            if (flip) tag = {tag, " R12 endian held"};
            check(rd == e, tag, 64'(rd), 64'(e));
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R5 ready returns", 64'(req_ready), 64'd1);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        void'($urandom(32'h5eed_a11c));
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'($urandom);
        for (int w = 0; w < 64; w++) mem[w] = ref_word(w);
        rst_n = 0; cfg_big_endian = 0; req_valid = 0; req_write = 0;
        req_size = 0; req_signed = 0; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
        check(bus_req == 1'b0, "R1 bus idle", 64'(bus_req), 64'd0);
        check(rsp_valid == 1'b0, "R1 no response", 64'(rsp_valid), 64'd0);

        // Split word store at offset 2, then read back both orders
        do_op(1, 2, 0, 32'h02, 32'h11223344, 0, 0);
        do_op(0, 2, 0, 32'h02, 0, 0, 0);
        do_op(0, 2, 0, 32'h02, 0, 1, 0);
        // Big-endian word of value 1 at address 4: bytes 00 00 00 01 upward (R7)
        do_op(1, 2, 0, 32'h04, 32'h00000001, 1, 0);
        check(mem[1] == 32'h01000000, "R7 R10 big-endian byte layout", 64'(mem[1]), 64'h01000000);
        // Sub-word extension
        do_op(1, 0, 0, 32'h09, 32'h000000F0, 0, 0);
        do_op(0, 0, 1, 32'h09, 0, 0, 0);
        do_op(0, 0, 0, 32'h09, 0, 0, 0);
        // Halfword across boundary, both orders, signed
        do_op(1, 1, 0, 32'h0B, 32'h0000ABCD, 1, 0);
        do_op(0, 1, 1, 32'h0B, 0, 1, 0);
        do_op(0, 1, 1, 32'h0B, 0, 0, 0);
        // Size code 3 acts as word
        do_op(1, 3, 0, 32'h13, 32'hCAFEF00D, 0, 0);
        do_op(0, 3, 0, 32'h13, 0, 0, 0);
        // Byte order changed mid-flight
        do_op(0, 2, 0, 32'h21, 0, 1, 1);
        do_op(1, 2, 0, 32'h25, 32'h89ABCDEF, 0, 1);
        // Wrap past top of address space
        do_op(1, 2, 0, 32'hFFFE, 32'h55667788, 0, 0);
        do_op(0, 2, 0, 32'hFFFE, 0, 0, 0);

        for (int i = 0; i < 400; i++) begin
            do_op(1'($urandom), int'($urandom % 4), 1'($urandom), int'($urandom % 256),
                  $urandom, 1'($urandom), ($urandom % 8) == 0);
        end
        done = 1;
        report();
    end
endmodule